// File: doc/BRIEF.md
# Exception Return Sequencer

This block carries out the return from an exception or interrupt handler for a privileged processor core. On `start` it samples the live status word, stack pointer and asynchronous-trap level. It then makes two longword reads from the stack through a single-beat read port. The first read returns the saved program counter and the second returns the saved status word. Each read takes the address from the working stack pointer, which then advances by 4.

The popped status word goes through a layered legality check against the live word. An illegal word ends the operation with a reserved-operand fault, and no architectural state changes. A legal word causes a save cycle, in which the post-pop stack pointer is written into a banked stack-pointer file. A switch cycle follows. It presents the new PC, status word and stack pointer together with their write strobes, pulses a prefetch flush, and can raise a level-2 software-interrupt request. A failed stack read stops the operation with a memory fault, and the stack pointer and bank keep their values.

The bank is internal and holds one pointer per access mode (0 kernel, 1 executive, 2 supervisor, 3 user) and a separate interrupt stack pointer. Status-word layout (bit positions): C 0, V 1, Z 2, N 3, T 4, IV 5, FU 6, DV 7, reserved 15:8, priority 20:16, reserved 21, previous mode 23:22, current mode 25:24, interrupt-stack flag 26, first-part-done 27, reserved 29:28, trace-pending 30, compatibility mode 31.

Top module: `xret_seq`

## Requirements
- R1: The first read uses the stack pointer sampled at `start`, and the second read uses that value plus 4. The outgoing stack pointer saved on success is the sampled value plus 8.
- R2: A reserved-operand fault is raised when the popped word meets any of these conditions, with every comparison unsigned:
  - its current mode is below the live current mode;
  - it sets the interrupt-stack flag (bit 26) while the live word has that flag clear;
  - it sets the interrupt-stack flag together with a nonzero current mode;
  - it sets the interrupt-stack flag together with a zero priority;
  - it has a nonzero priority together with a nonzero current mode;
  - its previous mode is below its current mode;
  - its priority is above the live priority;
  - any reserved bit (15:8, 21, 29:28) is set.
- R3: When the popped compatibility bit (31) is set, a reserved-operand fault is also raised if any of bits 27, 26, 7, 6 or 5 is set, or if the current mode is not 3.
- R4: A reserved-operand fault pulses `fault_rsvd` with `done`. In that cycle `commit`, `sp_we`, `flush` and `sw_irq2` stay low, and the bank keeps its contents.
- R5: On success, the save step writes the outgoing stack pointer into the interrupt stack pointer if the live interrupt-stack flag is set. Otherwise it writes it into the bank entry of the live current mode.
- R6: If the live trace-pending bit (30) is set, bit 30 of `sw_out` is 1 in the commit cycle.
- R7: In the commit cycle, `pc_out` equals the first popped longword. `sw_out` equals the second popped longword, apart from R6, so the condition codes in bits 3:0 come from the popped word.
- R8: In the commit cycle `sp_we` is high. `sp_out` is the interrupt stack pointer when the new interrupt-stack flag is set, and otherwise the bank entry of the new current mode, including a value written in the same operation.
- R9: `sw_irq2` is high in the commit cycle exactly when the new current mode is at least `trap_lvl`, compared unsigned. It is low at all other times.
- R10: A read answered with `rd_err` ends the operation with `fault_mem` and `done`. It makes no further read, does not commit, does not write `sp_we`, and leaves the bank unchanged.
- R11: `irq_hold` is high in the save cycle and in the commit cycle only, so for two cycles on success and never on a fault. `flush` pulses once, in the commit cycle.
- R12: After reset the sequencer is idle with `busy`, `done` and `rd_req` low, and every bank entry and the interrupt stack pointer are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a return; sampled while idle |
| cur_sp | input | AW | Live stack pointer |
| cur_sw | input | 32 | Live status word |
| trap_lvl | input | TRAP_W | Asynchronous-trap level |
| rd_req | output | 1 | Stack read request |
| rd_addr | output | AW | Stack read address |
| rd_ack | input | 1 | Read response valid |
| rd_err | input | 1 | Read access or translation fault |
| rd_data | input | 32 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final cycle of an operation |
| fault_rsvd | output | 1 | Reserved-operand fault |
| fault_mem | output | 1 | Stack read fault |
| commit | output | 1 | New PC and status word valid |
| pc_out | output | 32 | New program counter |
| sw_out | output | 32 | New status word |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_out | output | AW | New stack pointer |
| sw_irq2 | output | 1 | Level-2 software interrupt request |
| flush | output | 1 | Prefetch flush pulse |
| irq_hold | output | 1 | Hold off interrupt acceptance |

## Verification
A bank entry written to the wrong slot shows up later, when a return selects that mode and `sp_out` carries the stale value. The bench therefore keeps its own bank model across hundreds of chained operations, so a misplaced save can surface many returns after the fault that caused it. Errors in the check or in the handshake show at once, in the `done` cycle of the same operation: a wrong fault flag, a missing trace bit, or a wrong read address. Memory and reserved faults are mixed into the chain, so any corruption of the bank on a faulting return is caught by the next return that reads the affected entry.

// File: rtl/xret_pkg.sv
package xret_pkg;

   // Status word, most significant field first
   typedef struct packed {
      logic       cm;       // 31 compatibility mode
      logic       tp;       // 30 trace pending
      logic [1:0] rsv_hi;   // 29:28 reserved
      logic       fpd;      // 27 first part done
      logic       is;       // 26 interrupt stack
      logic [1:0] cmd;      // 25:24 current mode
      logic [1:0] pmd;      // 23:22 previous mode
      logic       rsv_mid;  // 21 reserved
      logic [4:0] ipl;      // 20:16 priority
      logic [7:0] rsv_lo;   // 15:8 reserved
      logic       dv;       // 7
      logic       fu;       // 6
      logic       iv;       // 5
      logic       t;        // 4
      logic       n;        // 3
      logic       z;        // 2
      logic       v;        // 1
      logic       c;        // 0
   } stat_t;

   typedef enum logic [2:0] {
      S_IDLE, S_RD_PC, S_RD_SW, S_CHECK, S_SAVE, S_SWITCH, S_RFLT, S_MFLT
   } xret_state_t;

endpackage

// File: rtl/xret_check.sv
module xret_check
   import xret_pkg::*;
#(
   parameter bit COMPAT_CHK = 1'b1
) (
   input  logic [1:0] live_cmd,
   input  logic       live_is,
   input  logic [4:0] live_ipl,
   input  stat_t      popped,
   output logic       bad
);
   logic bad_base;
   logic bad_cm;

   always_comb begin
      bad_base = (popped.cmd < live_cmd)
               | (popped.is & ~live_is)
               | (popped.is & (popped.cmd != 2'd0))
               | (popped.is & (popped.ipl == 5'd0))
               | ((popped.ipl != 5'd0) & (popped.cmd != 2'd0))
               | (popped.pmd < popped.cmd)
               | (popped.ipl > live_ipl)
               | (|popped.rsv_lo) | popped.rsv_mid | (|popped.rsv_hi);
   end

   generate
      if (COMPAT_CHK) begin : g_cm_on
         assign bad_cm = popped.cm &
                         ((popped.fpd | popped.is | popped.dv | popped.fu | popped.iv)
                          | (popped.cmd != 2'd3));
      end else begin : g_cm_off
         assign bad_cm = 1'b0;
      end
   endgenerate

   assign bad = bad_base | bad_cm;

endmodule

// File: rtl/xret_spbank.sv
module xret_spbank #(
   parameter int AW    = 32,
   parameter int MODES = 4,
   localparam int MW   = $clog2(MODES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_isp,
   input  logic [MW-1:0] wr_mode,
   input  logic [AW-1:0] wr_data,
   input  logic          rd_isp,
   input  logic [MW-1:0] rd_mode,
   output logic [AW-1:0] rd_data
);
   logic [AW-1:0]             isp_q;
   logic [MODES-1:0][AW-1:0]  bank_flat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                isp_q <= '0;
      else if (wr_en && wr_isp)  isp_q <= wr_data;
   end

   generate
      for (genvar g = 0; g < MODES; g++) begin : g_mode
         logic [AW-1:0] sp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sp_q <= '0;
            else if (wr_en && !wr_isp && wr_mode == MW'(g))
               sp_q <= wr_data;
         end
         assign bank_flat[g] = sp_q;
      end
   endgenerate

   assign rd_data = rd_isp ? isp_q : bank_flat[rd_mode];

   assert_isp_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_isp) |=> $stable(isp_q));

endmodule

// File: rtl/xret_seq.sv
module xret_seq
   import xret_pkg::*;
#(
   parameter int AW         = 32,
   parameter int MODES      = 4,
   parameter int TRAP_W     = 3,
   parameter int STEP       = 4,
   parameter bit COMPAT_CHK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [AW-1:0]     cur_sp,
   input  logic [31:0]       cur_sw,
   input  logic [TRAP_W-1:0] trap_lvl,
   output logic              rd_req,
   output logic [AW-1:0]     rd_addr,
   input  logic              rd_ack,
   input  logic              rd_err,
   input  logic [31:0]       rd_data,
   output logic              busy,
   output logic              done,
   output logic              fault_rsvd,
   output logic              fault_mem,
   output logic              commit,
   output logic [31:0]       pc_out,
   output logic [31:0]       sw_out,
   output logic              sp_we,
   output logic [AW-1:0]     sp_out,
   output logic              sw_irq2,
   output logic              flush,
   output logic              irq_hold
);
   localparam int MW = $clog2(MODES);
   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   generate
      if (MODES != 4) begin : g_bad_modes
         $error("xret_seq: MODES must be 4 to match the 2-bit mode field");
      end
      if (TRAP_W < 3) begin : g_bad_trap
         $error("xret_seq: TRAP_W must be at least 3");
      end
      if (AW < 8) begin : g_bad_aw
         $error("xret_seq: AW too small");
      end
   endgenerate

   xret_state_t       st;
   logic [AW-1:0]     sp_q;
   logic [31:0]       pc_q;
   stat_t             sw_q;
   stat_t             live_q;
   logic [TRAP_W-1:0] trap_q;
   logic              bad;
   stat_t             sw_new;

   // ---------------- sequencing ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         sp_q   <= '0;
         pc_q   <= '0;
         sw_q   <= '0;
         live_q <= '0;
         trap_q <= '0;
      end else begin
         unique case (st)
            S_IDLE: if (start) begin
               sp_q   <= cur_sp;
               live_q <= cur_sw;
               trap_q <= trap_lvl;
               st     <= S_RD_PC;
            end
            S_RD_PC: if (rd_ack) begin
               if (rd_err) st <= S_MFLT;
               else begin
                  pc_q <= rd_data;
                  sp_q <= sp_q + STEP_V;
                  st   <= S_RD_SW;
               end
            end
            S_RD_SW: if (rd_ack) begin
               if (rd_err) st <= S_MFLT;
               else begin
                  sw_q <= rd_data;
                  sp_q <= sp_q + STEP_V;
                  st   <= S_CHECK;
               end
            end
            S_CHECK:  st <= bad ? S_RFLT : S_SAVE;
            S_SAVE:   st <= S_SWITCH;
            default:  st <= S_IDLE;
         endcase
      end
   end

   xret_check #(.COMPAT_CHK(COMPAT_CHK)) u_check (
      .live_cmd (live_q.cmd),
      .live_is  (live_q.is),
      .live_ipl (live_q.ipl),
      .popped   (sw_q),
      .bad      (bad)
   );

   xret_spbank #(.AW(AW), .MODES(MODES)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (st == S_SAVE),
      .wr_isp  (live_q.is),
      .wr_mode (MW'(live_q.cmd)),
      .wr_data (sp_q),
      .rd_isp  (sw_q.is),
      .rd_mode (MW'(sw_q.cmd)),
      .rd_data (sp_out)
   );

   // ---------------- outputs ----------------
   always_comb begin
      sw_new    = sw_q;
      sw_new.tp = sw_q.tp | live_q.tp;
   end

   assign rd_req     = (st == S_RD_PC) || (st == S_RD_SW);
   assign rd_addr    = sp_q;
   assign busy       = (st != S_IDLE);
   assign commit     = (st == S_SWITCH);
   assign fault_rsvd = (st == S_RFLT);
   assign fault_mem  = (st == S_MFLT);
   assign done       = commit | fault_rsvd | fault_mem;
   assign pc_out     = pc_q;
   assign sw_out     = sw_new;
   assign sp_we      = commit;
   assign flush      = commit;
   assign sw_irq2    = commit && (TRAP_W'(sw_q.cmd) >= trap_q);
   assign irq_hold   = (st == S_SAVE) || commit;

   // ---------------- assertions ----------------
   assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RD_PC && rd_ack && !rd_err) |=> (rd_addr == $past(rd_addr) + STEP_V));

   assert_rsvd_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fault_rsvd |-> (!commit && !sp_we && !flush && !sw_irq2 && !irq_hold));

   assert_trace_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && live_q.tp) |-> sw_out[30]);

   assert_irq_at_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sw_irq2 |-> commit);

   assert_mem_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fault_mem |-> (!commit && !sp_we && !irq_hold && !rd_req));

   assert_hold_before_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> $past(irq_hold));

   assert_done_ends_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

endmodule

// File: tb/xret_seq_tb.sv
`timescale 1ns/1ps
module xret_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] cur_sp = '0;
   logic [31:0] cur_sw = '0;
   logic [2:0]  trap_lvl = '0;
   logic        rd_req;
   logic [31:0] rd_addr;
   logic        rd_ack = 1'b0;
   logic        rd_err = 1'b0;
   logic [31:0] rd_data = '0;
   logic        busy, done, fault_rsvd, fault_mem, commit, sp_we, sw_irq2, flush, irq_hold;
   logic [31:0] pc_out, sw_out, sp_out;

   int n_checks = 0;
   int n_fail   = 0;

   logic [31:0] bank_m [4];
   logic [31:0] isp_m;

   always #10 clk = ~clk;

   xret_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cur_sp(cur_sp), .cur_sw(cur_sw),
      .trap_lvl(trap_lvl), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
      .rd_err(rd_err), .rd_data(rd_data), .busy(busy), .done(done),
      .fault_rsvd(fault_rsvd), .fault_mem(fault_mem), .commit(commit),
      .pc_out(pc_out), .sw_out(sw_out), .sp_we(sp_we), .sp_out(sp_out),
      .sw_irq2(sw_irq2), .flush(flush), .irq_hold(irq_hold)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit cm, tp, fpd, is, input logic [1:0] cmd, pmd,
                                      input logic [4:0] ipl, input logic [7:0] low);
      return {cm, tp, 2'b00, fpd, is, cmd, pmd, 1'b0, ipl, 8'h00, low};
   endfunction

   // Legality per R2 and R3
   function automatic bit exp_bad(input logic [31:0] l, input logic [31:0] p);
      bit b;
      b = (p[25:24] < l[25:24]) || (p[26] && !l[26]) || (p[26] && p[25:24] != 0) ||
          (p[26] && p[20:16] == 0) || (p[20:16] != 0 && p[25:24] != 0) ||
          (p[23:22] < p[25:24]) || (p[20:16] > l[20:16]) ||
          (p[15:8] != 0) || p[21] || (p[29:28] != 0);
      if (p[31] && (p[27] || p[26] || p[7] || p[6] || p[5] || p[25:24] != 2'd3)) b = 1;
      return b;
   endfunction

   function automatic logic [31:0] mk_live();
      logic [1:0] c = 2'($urandom % 4);
      bit i = ($urandom % 3) == 0;
      if (i) c = 0;
      return mk(0, 1'($urandom), 0, i, c, 2'(c + $urandom % (4 - c)),
                5'($urandom), 8'($urandom));
   endfunction

   function automatic logic [31:0] mk_valid(input logic [31:0] l);
      logic [1:0] c;
      logic [4:0] ip;
      logic [7:0] low = 8'($urandom);
      if (l[26] && l[20:16] != 0 && ($urandom % 2) == 1) begin
         ip = 5'(1 + $urandom % l[20:16]);
         return mk(0, 1'($urandom), 1'($urandom), 1, 0, 2'($urandom), ip, low);
      end
      c  = 2'(l[25:24] + $urandom % (4 - l[25:24]));
      ip = (c == 0) ? 5'($urandom % (l[20:16] + 1)) : 5'd0;
      if (c == 3 && ($urandom % 3) == 0)
         return mk(1, 1'($urandom), 0, 0, 3, 3, 0, low & 8'h1F);
      return mk(0, 1'($urandom), 1'($urandom), 0, c, 2'(c + $urandom % (4 - c)), ip, low);
   endfunction

   task automatic run_op(input logic [31:0] lsw, input logic [31:0] esp, input logic [2:0] tl,
                         input logic [31:0] ppc, input logic [31:0] psw, input int errsel);
      int          n_rd = 0;
      int          holds = 0;
      int          flushes = 0;
      bit          got = 0;
      logic [31:0] a0 = '0, a1 = '0;
      bit          o_rf = 0, o_mf = 0, o_cm = 0, o_we = 0, o_irq = 0;
      logic [31:0] o_pc = '0, o_sw = '0, o_sp = '0;
      bit          bad;
      logic [31:0] nsw, esp_new, outsp;

      @(negedge clk);
      cur_sw = lsw; cur_sp = esp; trap_lvl = tl; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 20 && !got; k++) begin
         rd_ack = 0; rd_err = 0; rd_data = '0;
         if (rd_req) begin
            if (n_rd == 0) a0 = rd_addr; else a1 = rd_addr;
            n_rd++;
            rd_ack  = 1;
            rd_data = (n_rd == 1) ? ppc : psw;
            rd_err  = (errsel == n_rd);
         end
         if (irq_hold) holds++;
         if (flush)    flushes++;
         if (done) begin
            got = 1;
            o_rf = fault_rsvd; o_mf = fault_mem; o_cm = commit; o_we = sp_we;
            o_irq = sw_irq2; o_pc = pc_out; o_sw = sw_out; o_sp = sp_out;
         end
         if (!got) @(negedge clk);
      end
      rd_ack = 0; rd_err = 0;
      chk(got, "R12 done reached", 32'(got), 1);

      chk(a0 == esp, "R1 first read addr", a0, esp);
      if (errsel == 1) begin
         chk(n_rd == 1, "R10 no read after fault", n_rd, 1);
      end else begin
         chk(a1 == esp + 4, "R1 second read addr", a1, esp + 4);
      end

      if (errsel != 0) begin
         chk(o_mf && !o_rf && !o_cm && !o_we, "R10 memory fault quiet",
             {o_mf, o_rf, o_cm, o_we}, 32'b1000);
         chk(holds == 0 && flushes == 0, "R11 no hold on fault", holds, 0);
         return;
      end

      bad = exp_bad(lsw, psw);
      if (bad) begin
         chk(o_rf && !o_mf && !o_cm && !o_we && !o_irq, "R2/R3/R4 reserved fault",
             {o_rf, o_mf, o_cm, o_we, o_irq}, 32'b10000);
         chk(holds == 0 && flushes == 0, "R4 no flush or hold", flushes, 0);
         return;
      end

      outsp = esp + 8;
      if (lsw[26]) isp_m = outsp; else bank_m[lsw[25:24]] = outsp;
      nsw = psw | (lsw[30] ? 32'h4000_0000 : 32'h0);
      esp_new = nsw[26] ? isp_m : bank_m[nsw[25:24]];
      chk(o_cm && !o_rf && !o_mf, "R2 legal word commits", {o_cm, o_rf, o_mf}, 32'b100);
      chk(o_pc == ppc, "R7 pc_out", o_pc, ppc);
      chk(o_sw == nsw, "R6/R7 sw_out", o_sw, nsw);
      chk(o_sw[3:0] == psw[3:0], "R7 condition codes", o_sw[3:0], psw[3:0]);
      chk(o_we && o_sp == esp_new, "R5/R8 sp_out", o_sp, esp_new);
      chk(o_irq == ({1'b0, nsw[25:24]} >= tl), "R9 trap request", o_irq,
          32'({1'b0, nsw[25:24]} >= tl));
      chk(holds == 2 && flushes == 1, "R11 hold and flush", {holds[15:0], flushes[15:0]},
          32'h0002_0001);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [31:0] l, p;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4; i++) bank_m[i] = '0;
      isp_m = '0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !rd_req, "R12 reset idle", {busy, done, rd_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !rd_req, "R12 idle after reset", {busy, done, rd_req}, 0);

      // R12: kernel -> user, user bank entry still 0 from reset
      run_op(mk(0,0,0,0,0,0,0,0), 32'h1000, 3'd4, 32'h0000_8000, mk(0,0,0,0,3,3,0,8'h0A), 0);
      // R3: legal compatibility return, then illegal ones
      run_op(mk(0,0,0,0,3,3,0,0), 32'h2000, 3'd3, 32'h0000_9000, mk(1,0,0,0,3,3,0,8'h05), 0);
      run_op(mk(0,0,0,0,3,3,0,0), 32'h2100, 3'd3, 32'h0000_9100, mk(1,0,0,0,3,3,0,8'h20), 0);
      run_op(mk(0,0,0,0,2,3,0,0), 32'h2200, 3'd3, 32'h0000_9200, mk(1,0,0,0,2,3,0,8'h00), 0);
      // R2: each rule alone
      run_op(mk(0,0,0,0,2,2,0,0), 32'h3000, 3'd4, 1, mk(0,0,0,0,1,1,0,0), 0);
      run_op(mk(0,0,0,0,0,0,5,0), 32'h3000, 3'd4, 1, mk(0,0,0,1,0,0,1,0), 0);
      run_op(mk(0,0,0,0,0,0,5,0), 32'h3000, 3'd4, 1, mk(0,0,0,0,0,0,6,0), 0);
      run_op(mk(0,0,0,0,0,0,5,0), 32'h3000, 3'd4, 1, mk(0,0,0,0,2,1,0,0), 0);
      run_op(mk(0,0,0,0,0,0,5,0), 32'h3000, 3'd4, 1, mk(0,0,0,0,1,1,0,0) | 32'h0020_0000, 0);
      run_op(mk(0,0,0,1,0,0,5,0), 32'h3000, 3'd4, 1, mk(0,0,0,1,0,0,0,0), 0);
      // R5/R8: interrupt stack to interrupt stack, trace pending forced (R6)
      run_op(mk(0,1,0,1,0,0,9,0), 32'h4000, 3'd0, 32'hABCD_0000, mk(0,0,0,1,0,2,4,8'h0F), 0);
      // R9 boundaries
      run_op(mk(0,0,0,0,1,1,0,0), 32'h5000, 3'd1, 32'h10, mk(0,0,0,0,1,1,0,0), 0);
      run_op(mk(0,0,0,0,1,1,0,0), 32'h5100, 3'd2, 32'h14, mk(0,0,0,0,1,1,0,0), 0);
      // R10: fault on each pop
      run_op(mk(0,0,0,0,0,0,0,0), 32'h6000, 3'd4, 32'h20, mk(0,0,0,0,3,3,0,0), 1);
      run_op(mk(0,0,0,0,0,0,0,0), 32'h6100, 3'd4, 32'h24, mk(0,0,0,0,3,3,0,0), 2);
      // R1: address wrap
      run_op(mk(0,0,0,0,0,0,0,0), 32'hFFFF_FFFC, 3'd4, 32'h28, mk(0,0,0,0,0,0,0,0), 0);

      for (int i = 0; i < 400; i++) begin
         l = mk_live();
         p = mk_valid(l);
         if (($urandom % 5) < 2) p = p ^ (32'h1 << ($urandom % 32));
         run_op(l, {$urandom, 2'b00}, 3'($urandom % 5), $urandom, p,
                (($urandom % 12) == 0) ? int'(1 + $urandom % 2) : 0);
      end

      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule